// File: doc/BRIEF.md
# Memory Region Address Watch and Fault Flag Unit

This block sits beside three memory regions: an on-chip RAM, a data tightly-coupled RAM and an instruction tightly-coupled RAM. It follows each region's access stream. Every valid access is compared against a programmable watch granule of 8 bytes and a direction select. When an access matches, a per-region match flag is raised. A separate per-region error flag records pulses from the region's address decoder, which fires on accesses to unallocated addresses.

Six status flags are kept. A status-enable mask decides which events are allowed to latch into them. A separate signal-enable mask decides which latched flags drive the single interrupt line. Software clears a flag by writing a one to its status bit. A small register port holds the status register, the two masks and three watch registers. The port has a write strobe, a 3-bit word offset, and a read data path that is combinational from the offset.

Top module: `memwatch_unit`

## Requirements
- R1: After reset, every register reads zero and `irq` is low.
- R2: A valid access on region r (0 = on-chip RAM, 1 = data TCM, 2 = instruction TCM) whose address bits [15:3] equal the watch granule of region r, in the selected direction, sets status bit 3+r at the next clock edge, provided status-enable bit 3+r is set. Any byte within that 8-byte granule hits; bytes outside it do not.
- R3: Watch register bit 16 selects the direction. 0 matches reads only (`acc_wr` low) and 1 matches writes only. An access in the other direction, or with the valid strobe low, sets no flag.
- R4: A write to offset 0 (status) clears every status bit whose write-data bit is 1 and leaves the bits written 0 unchanged.
- R5: A pulse on `unalloc_pulse[r]` sets status bit r at the next edge, provided status-enable bit r is set.
- R6: An event whose status-enable bit (offset 1, bits [5:0]) is 0 does not set its status bit.
- R7: When a new event and a write-one-clear reach the same status bit in the same cycle, the bit ends up set.
- R8: `irq` is the OR over the six bits of status AND signal-enable (offset 2, bits [5:0]). It follows status in the same cycle, and signal-enable has no effect on latching.
- R9: Register offsets: 0 status, 1 status-enable, 2 signal-enable, 3/4/5 watch for regions 0/1/2. A watch register holds the granule in bits [12:0] and the direction in bit 16. Reads return the stored fields with all other bits zero, and offsets 6 and 7 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_vld | input | 3 | Per-region access valid strobe |
| acc_wr | input | 3 | Per-region access direction, 1 = write |
| acc_addr | input | 48 | Per-region 16-bit byte address, region r at bits [16r+15:16r] |
| unalloc_pulse | input | 3 | Per-region unallocated-access pulse |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq | output | 1 | Interrupt line |

## Verification
The bench sweeps three granules of addresses around each region's watch granule, in both access directions and under both direction selects. A compare at the wrong bit boundary would flag the neighbouring granule or miss bytes 1 to 7 of the watched one. A swapped direction sense would flag the wrong access type. The bench also aims at the collision of an event with a clear in the same cycle, where a clear-wins design would drop the event. It checks that the two masks stay independent: a design that gated latching with signal-enable would lose silent flags. It covers the extreme granules 0 and 0x1FFF, and partial clears, where a design that cleared on write-zero would wipe the other flags.

// File: rtl/mw_pkg.sv
package mw_pkg;
  localparam int MW_RAW = 3;
  localparam logic [MW_RAW-1:0] MW_OFF_STATUS = 3'd0;
  localparam logic [MW_RAW-1:0] MW_OFF_STEN   = 3'd1;
  localparam logic [MW_RAW-1:0] MW_OFF_SGEN   = 3'd2;
  localparam logic [MW_RAW-1:0] MW_OFF_WATCH0 = 3'd3;
endpackage

// File: rtl/mw_match.sv
module mw_match #(
  parameter int AW       = 16,
  parameter int GRAN_LSB = 3,
  localparam int GW      = AW - GRAN_LSB
) (
  input  logic          vld,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [GW-1:0] gran,
  input  logic          dir,
  output logic          hit
);
  function automatic logic [GW-1:0] granule_of(input logic [AW-1:0] a);
    return a[AW-1:GRAN_LSB];
  endfunction

  logic unused_low;
  assign unused_low = ^addr[GRAN_LSB-1:0];

  assign hit = vld && (wr == dir) && (granule_of(addr) == gran);
endmodule

// File: rtl/mw_status.sv
module mw_status #(
  parameter int NFLAG = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] evt,
  input  logic [NFLAG-1:0] stat_en,
  input  logic [NFLAG-1:0] w1c,
  output logic [NFLAG-1:0] status_q
);
  function automatic logic [NFLAG-1:0] next_status(
    input logic [NFLAG-1:0] cur, input logic [NFLAG-1:0] e,
    input logic [NFLAG-1:0] en, input logic [NFLAG-1:0] clr);
    return (cur & ~clr) | (e & en);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= next_status(status_q, evt, stat_en, w1c);
  end
endmodule

// File: rtl/mw_regfile.sv
module mw_regfile
  import mw_pkg::*;
#(
  parameter int NREG     = 3,
  parameter int GW       = 13,
  parameter int DW       = 32,
  parameter int WDIR_BIT = 16,
  localparam int NFLAG   = 2 * NREG
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_we,
  input  logic [MW_RAW-1:0]        reg_addr,
  input  logic [DW-1:0]            reg_wdata,
  input  logic [NFLAG-1:0]         status_q,
  output logic [NFLAG-1:0]         stat_en_q,
  output logic [NFLAG-1:0]         sig_en_q,
  output logic [NREG-1:0][GW-1:0]  watch_gran,
  output logic [NREG-1:0]          watch_dir,
  output logic [NFLAG-1:0]         w1c_mask,
  output logic [DW-1:0]            reg_rdata
);
  logic unused_wdata;
  assign unused_wdata = ^reg_wdata;

  assign w1c_mask = (reg_we && reg_addr == MW_OFF_STATUS) ? reg_wdata[NFLAG-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_en_q  <= '0;
      sig_en_q   <= '0;
      watch_gran <= '0;
      watch_dir  <= '0;
    end else if (reg_we) begin
      if (reg_addr == MW_OFF_STEN) stat_en_q <= reg_wdata[NFLAG-1:0];
      if (reg_addr == MW_OFF_SGEN) sig_en_q  <= reg_wdata[NFLAG-1:0];
      for (int r = 0; r < NREG; r++) begin
        if (reg_addr == MW_RAW'(int'(MW_OFF_WATCH0) + r)) begin
          watch_gran[r] <= reg_wdata[GW-1:0];
          watch_dir[r]  <= reg_wdata[WDIR_BIT];
        end
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == MW_OFF_STATUS) reg_rdata[NFLAG-1:0] = status_q;
    if (reg_addr == MW_OFF_STEN)   reg_rdata[NFLAG-1:0] = stat_en_q;
    if (reg_addr == MW_OFF_SGEN)   reg_rdata[NFLAG-1:0] = sig_en_q;
    for (int r = 0; r < NREG; r++) begin
      if (reg_addr == MW_RAW'(int'(MW_OFF_WATCH0) + r)) begin
        reg_rdata[GW-1:0]     = watch_gran[r];
        reg_rdata[WDIR_BIT]   = watch_dir[r];
      end
    end
  end
endmodule

// File: rtl/memwatch_unit.sv
module memwatch_unit
  import mw_pkg::*;
#(
  parameter int NREG     = 3,
  parameter int AW       = 16,
  parameter int GRAN_LSB = 3,
  parameter int DW       = 32,
  parameter int WDIR_BIT = 16,
  localparam int GW      = AW - GRAN_LSB,
  localparam int NFLAG   = 2 * NREG
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NREG-1:0]    acc_vld,
  input  logic [NREG-1:0]    acc_wr,
  input  logic [NREG*AW-1:0] acc_addr,
  input  logic [NREG-1:0]    unalloc_pulse,
  input  logic               reg_we,
  input  logic [MW_RAW-1:0]  reg_addr,
  input  logic [DW-1:0]      reg_wdata,
  output logic [DW-1:0]      reg_rdata,
  output logic               irq
);
  logic [NFLAG-1:0]        status_q;
  logic [NFLAG-1:0]        stat_en_q;
  logic [NFLAG-1:0]        sig_en_q;
  logic [NFLAG-1:0]        w1c_mask;
  logic [NREG-1:0][GW-1:0] watch_gran;
  logic [NREG-1:0]         watch_dir;
  logic [NREG-1:0]         match_hit;
  logic [NREG-1:0]         err_evt;
  logic [NFLAG-1:0]        flag_evt;

  mw_regfile #(.NREG(NREG), .GW(GW), .DW(DW), .WDIR_BIT(WDIR_BIT)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .status_q(status_q), .stat_en_q(stat_en_q),
    .sig_en_q(sig_en_q), .watch_gran(watch_gran), .watch_dir(watch_dir),
    .w1c_mask(w1c_mask), .reg_rdata(reg_rdata)
  );

  for (genvar r = 0; r < NREG; r++) begin : g_region
    mw_match #(.AW(AW), .GRAN_LSB(GRAN_LSB)) u_match (
      .vld(acc_vld[r]), .wr(acc_wr[r]), .addr(acc_addr[r*AW +: AW]),
      .gran(watch_gran[r]), .dir(watch_dir[r]), .hit(match_hit[r])
    );
  end

  assign err_evt  = unalloc_pulse;
  assign flag_evt = {match_hit, err_evt};

  mw_status #(.NFLAG(NFLAG)) u_status (
    .clk(clk), .rst_n(rst_n), .evt(flag_evt), .stat_en(stat_en_q),
    .w1c(w1c_mask), .status_q(status_q)
  );

  assign irq = |(status_q & sig_en_q);
endmodule

// File: rtl/mw_checker.sv
module mw_checker #(
  parameter int NREG  = 3,
  parameter int NFLAG = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq,
  input logic [NREG-1:0]  acc_vld,
  input logic [NREG-1:0]  acc_wr,
  input logic [NREG-1:0]  watch_dir,
  input logic [NREG-1:0]  match_hit,
  input logic [NFLAG-1:0] flag_evt,
  input logic [NFLAG-1:0] status_q,
  input logic [NFLAG-1:0] stat_en_q,
  input logic [NFLAG-1:0] w1c_mask
);
  logic seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  a_r3_direction_and_valid: assert property (@(posedge clk) disable iff (!rst_n)
    ((match_hit & ((acc_wr ^ watch_dir) | ~acc_vld)) == '0));

  a_r7_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> (($past(flag_evt & stat_en_q) & ~status_q) == '0));

  a_r4_clear_only_by_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> (($past(status_q) & ~status_q & ~$past(w1c_mask)) == '0));

  a_r6_gated_set: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> ((status_q & ~$past(status_q) & ~$past(stat_en_q)) == '0));

  a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (status_q != '0));
endmodule

bind memwatch_unit mw_checker #(.NREG(NREG), .NFLAG(NFLAG)) u_chk (.*);

// File: tb/test_memwatch_unit.sv
`timescale 1ns/1ps
module test_memwatch_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  acc_vld = '0;
  logic [2:0]  acc_wr = '0;
  logic [47:0] acc_addr = '0;
  logic [2:0]  unalloc_pulse = '0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  memwatch_unit i_memwatch_unit (
    .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .acc_wr(acc_wr),
    .acc_addr(acc_addr), .unalloc_pulse(unalloc_pulse), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic access(input int r, input logic w, input logic [15:0] a);
    @(negedge clk);
    acc_vld[r] = 1'b1; acc_wr[r] = w; acc_addr[r*16 +: 16] = a;
    @(negedge clk);
    acc_vld = '0;
  endtask

  task automatic pulse_err(input logic [2:0] m);
    @(negedge clk);
    unalloc_pulse = m;
    @(negedge clk);
    unalloc_pulse = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd_reg(3'(a), d);
      check($sformatf("R1 reset reg %0d", a), d, 32'h0);
    end
    check("R1 irq at reset", {31'h0, irq}, 32'h0);

    // R6 nothing latches while status-enable is zero
    pulse_err(3'b111);
    rd_reg(3'd0, d);
    check("R6 disabled error pulses", d, 32'h0);

    wr_reg(3'd1, 32'h3F);

    // R2 R3 R9 sweep: granule boundaries, both directions, both selects
    for (int r = 0; r < 3; r++) begin
      for (int dsel = 0; dsel < 2; dsel++) begin
        logic [12:0] g;
        g = 13'(13'h0A5 + r * 200 + dsel * 37);
        wr_reg(3'(3 + r), (32'(dsel) << 16) | 32'(g));
        rd_reg(3'(3 + r), d);
        check("R9 watch readback", d, (32'(dsel) << 16) | 32'(g));
        for (int off = 0; off < 24; off++) begin
          for (int w = 0; w < 2; w++) begin
            logic [15:0] a;
            logic [31:0] exp;
            a = 16'((int'(g) - 1) * 8 + off);
            exp = (((a >> 3) == 16'(g)) && (w == dsel)) ? (32'h1 << (3 + r)) : 32'h0;
            access(r, 1'(w), a);
            rd_reg(3'd0, d);
            check($sformatf("R2/R3 region %0d addr %h wr %0d sel %0d", r, a, w, dsel), d, exp);
            wr_reg(3'd0, 32'h3F);
          end
        end
      end
    end

    // R3 invalid strobe never matches
    wr_reg(3'd3, 32'h0001_0010);
    @(negedge clk);
    acc_vld = '0; acc_wr[0] = 1'b1; acc_addr[15:0] = 16'h0080;
    @(negedge clk);
    rd_reg(3'd0, d);
    check("R3 strobe low ignored", d, 32'h0);

    // R2 extreme granules
    wr_reg(3'd4, 32'h0000_0000);
    access(1, 1'b0, 16'h0007);
    rd_reg(3'd0, d);
    check("R2 granule 0 top byte", d, 32'h10);
    wr_reg(3'd0, 32'h3F);
    wr_reg(3'd5, 32'h0001_1FFF);
    access(2, 1'b1, 16'hFFFF);
    rd_reg(3'd0, d);
    check("R2 granule max", d, 32'h20);
    wr_reg(3'd0, 32'h3F);

    // R5 error pulses per region
    for (int r = 0; r < 3; r++) begin
      pulse_err(3'(1 << r));
      rd_reg(3'd0, d);
      check($sformatf("R5 error region %0d", r), d, 32'h1 << r);
      wr_reg(3'd0, 32'h3F);
    end

    // R4 partial clear
    pulse_err(3'b111);
    wr_reg(3'd0, 32'h2);
    rd_reg(3'd0, d);
    check("R4 write one clears only bit 1", d, 32'h5);
    wr_reg(3'd0, 32'h0);
    rd_reg(3'd0, d);
    check("R4 write zero no effect", d, 32'h5);

    // R7 event wins over clear in the same cycle, neighbour still clears
    @(negedge clk);
    unalloc_pulse = 3'b001; reg_we = 1'b1; reg_addr = 3'd0; reg_wdata = 32'h5;
    @(negedge clk);
    unalloc_pulse = '0; reg_we = 1'b0;
    rd_reg(3'd0, d);
    check("R7 collision keeps bit 0", d, 32'h1);

    // R8 irq gating by signal-enable, latching independent of it
    check("R8 irq off with sig-en zero", {31'h0, irq}, 32'h0);
    wr_reg(3'd2, 32'h2);
    check("R8 irq off unmasked flag absent", {31'h0, irq}, 32'h0);
    wr_reg(3'd2, 32'h1);
    check("R8 irq on", {31'h0, irq}, 32'h1);
    wr_reg(3'd0, 32'h1);
    check("R8 irq drops with clear", {31'h0, irq}, 32'h0);
    wr_reg(3'd2, 32'h0);
    pulse_err(3'b100);
    rd_reg(3'd0, d);
    check("R8 latch with sig-en zero", d, 32'h4);
    rd_reg(3'd2, d);
    check("R9 sig-en readback", d, 32'h0);
    rd_reg(3'd1, d);
    check("R9 stat-en readback", d, 32'h3F);

    // R6 masked bit stays clear while others latch
    wr_reg(3'd0, 32'h3F);
    wr_reg(3'd1, 32'h3D);
    pulse_err(3'b011);
    rd_reg(3'd0, d);
    check("R6 masked bit 1", d, 32'h1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule